// File: doc/BRIEF.md
# Reaction Guessing Game Controller

This block runs a small reaction game. A single lit lamp out of a row of lamps steps along the row, but it only moves on clock ticks that a free-running pseudorandom bit sequence allows. The player therefore cannot predict when the lamp will move. The player presses the button that sits beside a lamp. When a press is seen, play freezes with every lamp dark. The error output then says whether the pressed button was the one next to the lamp that was lit just before that tick.

Play restarts from the first lamp once every button has been released. The block expects buttons that have already been debounced and a slow game clock, both supplied from outside. A parameter selects how the state is stored. One choice is a compact binary phase-plus-index register. The other is an output-coded register, in which the lamp and error outputs are themselves the state bits.

Top module: `guess_game`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `lamp` is 4'b0001 (lamp index 0 lit) and `err` is 0. Reset loads the pseudorandom register with the seed 8'hE1. Reset acts at once and does not wait for a clock edge.
- R2: The 8-bit pseudorandom register steps on every clock as q <= {q[6:0], q[7]^q[5]^q[4]^q[3]}, which is the polynomial x^8+x^6+x^5+x^4+1. Its bit q[0] before the edge is the advance enable for that edge. The register never holds zero.
- R3: During play with no button pressed, an edge with the advance enable set moves the lit lamp from index i to index i+1, and the last index wraps to index 0. An edge with the advance enable clear leaves `lamp` unchanged.
- R4: At most one bit of `lamp` is ever set. When `err` is 1, every lamp is dark.
- R5: During play, an edge that samples exactly one pressed button, matching the lit lamp, enters the correct-hold state: `lamp` = 0 and `err` = 0. This holds whether the advance enable is set or clear.
- R6: During play, an edge that samples exactly one pressed button that does not match the lit lamp enters the wrong-hold state: `lamp` = 0 and `err` = 1. This includes the lamp that the same edge would have advanced to.
- R7: During play, an edge that samples two or more pressed buttons enters the wrong-hold state.
- R8: In either hold state, while any button is pressed, `lamp` stays 0 and `err` keeps its value. This holds whatever the advance enable does and whichever buttons change.
- R9: In either hold state, the first edge that samples all buttons released returns to play with `lamp` = 4'b0001 and `err` = 0.
- R10: The output-coded storage option (`OUT_CODED` = 1) gives the same port behaviour, cycle for cycle, as the binary option.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Game clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| btn | input | 4 | Debounced buttons, bit i beside lamp i |
| lamp | output | 4 | Lamp drive, one-hot during play, zero while held |
| err | output | 1 | Wrong-guess indication |

## Verification
Every cycle, the assertions check the following:
- the lamp vector stays one-hot or dark, and the error output is never on together with a lamp;
- a press always leads into a hold state, with the error value set by the guess;
- the hold is frozen while any button is pressed, and release returns to the first lamp;
- the lamp moves exactly on the enable bit, and the pseudorandom register never reaches zero.

Only the bench scenarios can show that the enable follows the stated polynomial and seed. They also show that a correct press is honoured on ticks with the enable set and on ticks with it clear, that a press of the lamp about to light counts as wrong, that a mid-game reset restarts the sequence, and that both storage options produce identical outputs.

// File: rtl/guess_pkg.sv
package guess_pkg;
  typedef enum logic [1:0] {
    K_PLAY = 2'd0,
    K_OK   = 2'd1,
    K_BAD  = 2'd2
  } phase_e;
endpackage

// File: rtl/guess_lfsr.sv
module guess_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'hE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] q,
  output logic         adv
);
  logic [W-1:0] q_nxt;

  // feedback is the parity of the tapped bits, shifted in at bit 0
  always_comb begin
    q_nxt = {q[W-2:0], ^(q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= q_nxt;
  end

  assign adv = q[0];
endmodule

// File: rtl/guess_judge.sv
module guess_judge #(
  parameter int N = 4
) (
  input  logic [N-1:0] btn,
  input  logic [N-1:0] lamp,
  output logic         press,
  output logic         match
);
  // a guess is good only when the pressed set equals the single lit lamp
  always_comb begin
    press = |btn;
    match = (btn == lamp) && (lamp != '0);
  end
endmodule

// File: rtl/guess_fsm.sv
module guess_fsm
  import guess_pkg::*;
#(
  parameter int N         = 4,
  parameter bit OUT_CODED = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         press,
  input  logic         match,
  output logic [N-1:0] lamp,
  output logic         err
);
  localparam int          IW    = (N > 1) ? $clog2(N) : 1;
  localparam logic [N-1:0] FIRST = N'(1);

  phase_e       cur_ph, nxt_ph;
  logic [N-1:0] cur_lamp, nxt_lamp;

  // next-state process, independent of storage choice
  always_comb begin
    nxt_ph   = cur_ph;
    nxt_lamp = cur_lamp;
    case (cur_ph)
      K_PLAY: begin
        if (press) begin
          nxt_ph   = match ? K_OK : K_BAD;
          nxt_lamp = '0;
        end else if (adv) begin
          nxt_lamp = {cur_lamp[N-2:0], cur_lamp[N-1]};
        end
      end
      K_OK, K_BAD: begin
        if (!press) begin
          nxt_ph   = K_PLAY;
          nxt_lamp = FIRST;
        end
      end
      default: begin
        nxt_ph   = K_PLAY;
        nxt_lamp = FIRST;
      end
    endcase
  end

  generate
    if (OUT_CODED) begin : g_oc
      // state bits are the outputs themselves: {lamps, error}
      logic [N-1:0] lamp_q;
      logic         err_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lamp_q <= FIRST;
          err_q  <= 1'b0;
        end else begin
          lamp_q <= nxt_lamp;
          err_q  <= (nxt_ph == K_BAD);
        end
      end

      always_comb begin
        cur_lamp = lamp_q;
        if (|lamp_q)    cur_ph = K_PLAY;
        else if (err_q) cur_ph = K_BAD;
        else            cur_ph = K_OK;
      end
    end else begin : g_bin
      phase_e        ph_q;
      logic [IW-1:0] idx_q, idx_nxt;

      always_comb begin
        idx_nxt = '0;
        for (int i = 0; i < N; i++) begin
          if (nxt_lamp[i]) idx_nxt = IW'(i);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ph_q  <= K_PLAY;
          idx_q <= '0;
        end else begin
          ph_q  <= nxt_ph;
          idx_q <= idx_nxt;
        end
      end

      always_comb begin
        cur_ph   = ph_q;
        cur_lamp = '0;
        if (ph_q == K_PLAY) cur_lamp[idx_q] = 1'b1;
      end
    end
  endgenerate

  assign lamp = cur_lamp;
  assign err  = (cur_ph == K_BAD);
endmodule

// File: rtl/guess_game.sv
module guess_game #(
  parameter int   N         = 4,
  parameter int   RW        = 8,
  parameter logic [RW-1:0] TAPS = 8'hB8,
  parameter logic [RW-1:0] SEED = 8'hE1,
  parameter bit   OUT_CODED = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] btn,
  output logic [N-1:0] lamp,
  output logic         err
);
  logic [RW-1:0] lfsr_w;
  logic          adv_w;
  logic          press_w;
  logic          match_w;

  guess_lfsr #(.W(RW), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .q     (lfsr_w),
    .adv   (adv_w)
  );

  guess_judge #(.N(N)) u_judge (
    .btn   (btn),
    .lamp  (lamp),
    .press (press_w),
    .match (match_w)
  );

  guess_fsm #(.N(N), .OUT_CODED(OUT_CODED)) u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv_w),
    .press (press_w),
    .match (match_w),
    .lamp  (lamp),
    .err   (err)
  );
endmodule

// File: rtl/guess_game_chk.sv
module guess_game_chk #(
  parameter int N  = 4,
  parameter int RW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  btn,
  input logic [N-1:0]  lamp,
  input logic          err,
  input logic          adv,
  input logic [RW-1:0] lfsr
);
  function automatic logic [N-1:0] rotl(input logic [N-1:0] v);
    return {v[N-2:0], v[N-1]};
  endfunction

  AST_LAMP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lamp)); // R4
  AST_ERR_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (lamp == '0)); // R4
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0); // R2
  AST_STEP_ON_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp != '0 && btn == '0 && adv) |=> (lamp == rotl($past(lamp)))); // R3
  AST_STAY_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp != '0 && btn == '0 && !adv) |=> $stable(lamp)); // R3
  AST_GOOD_GUESS: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp != '0 && btn == lamp) |=> (lamp == '0 && !err)); // R5
  AST_BAD_GUESS: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp != '0 && btn != '0 && btn != lamp) |=> (lamp == '0 && err)); // R6
  AST_MULTI_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp != '0 && $countones(btn) > 1) |=> err); // R7
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp == '0 && btn != '0) |=> (lamp == '0 && $stable(err))); // R8
  AST_RELEASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp == '0 && btn == '0) |=> (lamp == N'(1) && !err)); // R9
endmodule

bind guess_game guess_game_chk #(.N(N), .RW(RW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .btn   (btn),
  .lamp  (lamp),
  .err   (err),
  .adv   (adv_w),
  .lfsr  (lfsr_w)
);

// File: tb/guess_game_bench.sv
module guess_game_bench;
  localparam logic [7:0] SEED = 8'hE1;
  localparam logic [7:0] TAPS = 8'hB8;
  localparam int NPLAN = 14;
  // each entry: {repeat count, button pattern}
  localparam logic [7:0] PLAN [NPLAN] = '{
    {4'd12, 4'b0000}, {4'd1, 4'b0001}, {4'd3, 4'b0001}, {4'd2, 4'b0000},
    {4'd5,  4'b0000}, {4'd1, 4'b0100}, {4'd2, 4'b0110}, {4'd1, 4'b0000},
    {4'd7,  4'b0000}, {4'd1, 4'b1001}, {4'd1, 4'b0000}, {4'd9, 4'b0000},
    {4'd1,  4'b0010}, {4'd2, 4'b0000}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] btn;
  logic [3:0] lamp_a, lamp_b;
  logic       err_a, err_b;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_lfsr;
  logic [3:0] m_lamp;
  logic       m_err;
  string      m_tag;

  always #5 clk = ~clk;

  guess_game #(.OUT_CODED(1'b0)) u_guess_game (
    .clk(clk), .rst_n(rst_n), .btn(btn), .lamp(lamp_a), .err(err_a));
  guess_game #(.OUT_CODED(1'b1)) u_guess_game_oc (
    .clk(clk), .rst_n(rst_n), .btn(btn), .lamp(lamp_b), .err(err_b));

  task automatic cmp(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    cmp(m_tag, {lamp_a, err_a}, {m_lamp, m_err});
    cmp({"R10 ", m_tag}, {lamp_b, err_b}, {m_lamp, m_err});
    checks++;
    if ($countones(lamp_a) > 1 || (err_a && lamp_a != 4'b0)) begin
      errors++;
      $display("FAIL R4 actual %b expected one-hot or dark", {lamp_a, err_a});
    end
  endtask

  task automatic model_tick(input logic [3:0] b);
    logic a;
    a      = m_lfsr[0];
    m_lfsr = {m_lfsr[6:0], ^(m_lfsr & TAPS)};
    if (m_lamp != 4'b0) begin
      if (b != 4'b0) begin
        if ($countones(b) > 1)  begin m_tag = "R7"; m_err = 1'b1; end
        else if (b == m_lamp)   begin m_tag = "R5"; m_err = 1'b0; end
        else                    begin m_tag = "R6"; m_err = 1'b1; end
        m_lamp = 4'b0;
      end else begin
        m_tag = a ? "R2 R3 step" : "R3 stay";
        if (a) m_lamp = {m_lamp[2:0], m_lamp[3]};
      end
    end else if (b != 4'b0) begin
      m_tag = "R8";
    end else begin
      m_tag  = "R9";
      m_lamp = 4'b0001;
      m_err  = 1'b0;
    end
  endtask

  task automatic step(input logic [3:0] b);
    btn = b;
    @(posedge clk);
    model_tick(b);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #3;
    m_lfsr = SEED; m_lamp = 4'b0001; m_err = 1'b0; m_tag = "R1";
    compare_all();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare_all();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    btn = 4'b0;
    @(negedge clk);
    do_reset();                                    // R1

    for (int i = 0; i < NPLAN; i++) begin
      for (int k = 0; k < int'(PLAN[i][7:4]); k++) step(PLAN[i][3:0]);
    end

    // R5 with advance enable set on the pressing edge
    for (int t = 0; t < 40 && m_lfsr[0] !== 1'b1; t++) step(4'b0);
    step(m_lamp);
    step(4'b1000);                                 // R8 button change in hold
    step(4'b0);                                    // R9
    // R5 with advance enable clear on the pressing edge
    for (int t = 0; t < 40 && m_lfsr[0] !== 1'b0; t++) step(4'b0);
    step(m_lamp);
    step(4'b0);
    // R6 pressing the lamp that this edge would advance to
    for (int t = 0; t < 40 && m_lfsr[0] !== 1'b1; t++) step(4'b0);
    step({m_lamp[2:0], m_lamp[3]});
    for (int t = 0; t < 10; t++) step(4'b1111);    // R8 err held
    step(4'b0);                                    // R9

    // R2 full pseudorandom period and more
    for (int t = 0; t < 600; t++) step(4'b0);

    // R1 mid-game reset restarts sequence
    step(4'b0010);
    do_reset();
    for (int t = 0; t < 30; t++) step(4'b0);
    step(4'b0011);                                 // R7
    step(4'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule